// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller that splits its pins into banks of up to 32. Each bank owns a full set of word registers: a read-only synchronised pin level, a direction word, a write-one-to-set and a write-one-to-clear port onto the output latch, separate rising and falling edge enables, a sticky edge status word cleared by writing ones, and a mask that decides which status bits may raise the interrupt. Software drives outputs with single atomic writes instead of read-modify-write sequences, and it acknowledges edges bit by bit.

The register map is split into two windows. The first three banks sit in the low window and any further banks sit in a second window 0x100 bytes higher, with a gap between the two. Inside a window, each register kind has a fixed base offset and the bank number selects one of three consecutive words. A parameter mask selects pins whose direction bit has the opposite sense. Reads are combinational on a single-cycle bus; writes take effect on the next clock edge. The last bank may be partly populated, and its missing lanes are tied off.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After reset every `pin_out` and `pin_oe` bit is 0, `irq` is 0, and the edge enables, edge status and mask of every bank read 0; the direction word reads 1 exactly at the pins chosen by `INV_DIR_MASK` and 0 elsewhere.
- R2: A register of bank n lies at byte address `off + 4*n` for n = 0..2 and at `0x100 + off + 4*(n-3)` for n = 3..5, where `off` is 0x00 level, 0x0C direction, 0x18 set, 0x24 clear, 0x30 rising enable, 0x3C falling enable, 0x48 edge status and 0x9C edge mask; any other address (including any with an address bit above bit 8 set, a misaligned one, or a bank beyond the last) reads 0 and a write to it changes nothing.
- R3: Writing a word to a bank's set register drives high every `pin_out` of that bank whose write bit is 1 and leaves the others unchanged; the set register reads 0.
- R4: Writing a word to a bank's clear register drives low every `pin_out` of that bank whose write bit is 1 and leaves the others unchanged; the clear register reads 0.
- R5: `pin_oe` of a pin is its direction bit, except for pins chosen by `INV_DIR_MASK`, where a direction bit of 0 enables the output.
- R6: The level register reads each pin input through a two-flop synchroniser, so a change driven before clock edge k reads back after edge k+1; writes to the level register are ignored.
- R7: With its rising enable set, a 0-to-1 transition of a pin sets its edge status bit after clock edge k+2 when the pin changed before edge k.
- R8: With its falling enable set, a 1-to-0 transition sets the status bit with the same latency; with both enables set either transition sets it, and with neither set no transition does.
- R9: Writing 1 to an edge status bit clears it, writing 0 leaves it unchanged, and writing all ones clears the whole bank; status bits never clear otherwise.
- R10: When a new edge and a clearing write hit the same status bit in the same cycle, the bit ends set.
- R11: `irq` is 1 exactly when some bank has a status bit set whose mask bit is 1; mask bits are plain read/write.
- R12: In a bank with fewer than 32 pins, the missing lanes read 0 in every register and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, acts on the next clock edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Output enables, 1 drives the pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The two functions that can meet in the same cycle are the capture of a fresh edge into the status word and a software write that clears the same status bit. The bench lines this up by driving a rising transition on a pin with its rising enable on, waiting exactly one more cycle, and issuing the clearing write so that it is sampled on the very edge where the synchronised transition is detected. The status word is then read back through the bus and must still show the bit set, while a reference model on every clock also confirms that an ordinary clear without a coinciding edge removes it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int GB_BANK_W    = 32;
   localparam int GB_MAX_BANKS = 6;
   localparam int GB_WIN_BANKS = 3;
   localparam int GB_NUM_TYPES = 8;

   typedef enum logic [2:0] {
      RT_LEVEL = 3'd0,
      RT_DIR   = 3'd1,
      RT_SET   = 3'd2,
      RT_CLR   = 3'd3,
      RT_RISE  = 3'd4,
      RT_FALL  = 3'd5,
      RT_STAT  = 3'd6,
      RT_MASK  = 3'd7
   } gb_reg_e;

   typedef struct packed {
      logic    hit;
      gb_reg_e rtype;
      logic [2:0] bank;
   } gb_dec_t;

   // Byte offset of the first bank's copy of each register kind inside a window.
   function automatic logic [7:0] gb_type_offset(input gb_reg_e t);
      case (t)
         RT_LEVEL: return 8'h00;
         RT_DIR:   return 8'h0C;
         RT_SET:   return 8'h18;
         RT_CLR:   return 8'h24;
         RT_RISE:  return 8'h30;
         RT_FALL:  return 8'h3C;
         RT_STAT:  return 8'h48;
         default:  return 8'h9C;
      endcase
   endfunction

   // Decodes the low nine address bits: bit 8 picks the window, the rest the word.
   function automatic gb_dec_t gb_decode(input logic [8:0] a, input int nbanks);
      gb_dec_t r;
      int rel;
      int cand;
      r.hit   = 1'b0;
      r.rtype = RT_LEVEL;
      r.bank  = 3'd0;
      for (int t = 0; t < GB_NUM_TYPES; t++) begin
         rel = int'(a[7:0]) - int'(gb_type_offset(gb_reg_e'(3'(t))));
         if (a[1:0] == 2'b00 && rel >= 0 && rel <= 8) begin
            cand = (a[8] ? GB_WIN_BANKS : 0) + rel / 4;
            if (cand < nbanks) begin
               r.hit   = 1'b1;
               r.rtype = gb_reg_e'(3'(t));
               r.bank  = 3'(cand);
            end
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_bank_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_BANKS = 6
)(
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output gb_reg_e           rtype,
   output logic [2:0]        bank
);

   localparam int HI_W = ADDR_W - 9;

   gb_dec_t dec;
   logic    upper_ok;

   assign upper_ok = (addr[ADDR_W-1:9] == HI_W'(0));

   always_comb begin
      dec   = gb_decode(addr[8:0], NUM_BANKS);
      hit   = dec.hit & upper_ok;
      rtype = dec.rtype;
      bank  = dec.bank;
   end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] meta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         q      <= '0;
      end else begin
         meta_q <= d;
         q      <= meta_q;
      end
   end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int              PINS = 32,
   parameter logic [PINS-1:0] INV  = '0
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] pin_in,
   input  logic            wr,
   input  gb_reg_e         rtype,
   input  logic [PINS-1:0] wd,
   output logic [31:0]     rdata,
   output logic [PINS-1:0] pin_out,
   output logic [PINS-1:0] pin_oe,
   output logic [PINS-1:0] stat_q,
   output logic [PINS-1:0] mask_q,
   output logic            irq
);

   logic [PINS-1:0] lvl;
   logic [PINS-1:0] lvl_prev;
   logic [PINS-1:0] out_q;
   logic [PINS-1:0] dir_q;
   logic [PINS-1:0] rise_q;
   logic [PINS-1:0] fall_q;
   logic [PINS-1:0] edge_ev;
   logic [PINS-1:0] stat_clr;

   gpio_sync #(.W(PINS)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (lvl)
   );

   assign edge_ev  = (lvl & ~lvl_prev & rise_q) | (~lvl & lvl_prev & fall_q);
   assign stat_clr = (wr && rtype == RT_STAT) ? wd : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev <= '0;
         out_q    <= '0;
         dir_q    <= INV;
         rise_q   <= '0;
         fall_q   <= '0;
         stat_q   <= '0;
         mask_q   <= '0;
      end else begin
         lvl_prev <= lvl;
         // a fresh edge overrides a clearing write to the same bit
         stat_q   <= (stat_q & ~stat_clr) | edge_ev;
         if (wr) begin
            unique case (rtype)
               RT_DIR:  dir_q  <= wd;
               RT_SET:  out_q  <= out_q | wd;
               RT_CLR:  out_q  <= out_q & ~wd;
               RT_RISE: rise_q <= wd;
               RT_FALL: fall_q <= wd;
               RT_MASK: mask_q <= wd;
               default: ;
            endcase
         end
      end
   end

   generate
      if (INV == '0) begin : g_plain_dir
         assign pin_oe = dir_q;
      end else begin : g_inv_dir
         assign pin_oe = dir_q ^ INV;
      end
   endgenerate

   assign pin_out = out_q;
   assign irq     = |(stat_q & mask_q);

   always_comb begin
      rdata = '0;
      unique case (rtype)
         RT_LEVEL: rdata[PINS-1:0] = lvl;
         RT_DIR:   rdata[PINS-1:0] = dir_q;
         RT_RISE:  rdata[PINS-1:0] = rise_q;
         RT_FALL:  rdata[PINS-1:0] = fall_q;
         RT_STAT:  rdata[PINS-1:0] = stat_q;
         RT_MASK:  rdata[PINS-1:0] = mask_q;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int           NUM_PINS     = 176,
   parameter int           ADDR_W       = 12,
   parameter logic [191:0] INV_DIR_MASK = 192'hF << 86
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq
);

   localparam int NUM_BANKS = (NUM_PINS + GB_BANK_W - 1) / GB_BANK_W;
   localparam int LAST_PINS = NUM_PINS - GB_BANK_W * (NUM_BANKS - 1);
   localparam int LANE0     = (NUM_PINS < GB_BANK_W) ? NUM_PINS : GB_BANK_W;

   generate
      if (NUM_PINS < 1 || NUM_PINS > GB_MAX_BANKS * GB_BANK_W) begin : g_bad_pins
         $error("gpio_banked_ctrl: NUM_PINS out of range");
      end
      if (ADDR_W < 10) begin : g_bad_addr
         $error("gpio_banked_ctrl: ADDR_W must be at least 10");
      end
   endgenerate

   logic        dec_hit;
   gb_reg_e     dec_type;
   logic [2:0]  dec_bank;

   logic [31:0]          bank_rdata [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_irq;
   logic [NUM_PINS-1:0]  stat_all;
   logic [NUM_PINS-1:0]  mask_all;

   gpio_addr_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_BANKS (NUM_BANKS)
   ) u_dec (
      .addr  (bus_addr),
      .hit   (dec_hit),
      .rtype (dec_type),
      .bank  (dec_bank)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam int BP = (b == NUM_BANKS - 1) ? LAST_PINS : GB_BANK_W;
         localparam int LO = b * GB_BANK_W;
         localparam logic [BP-1:0] BINV = INV_DIR_MASK[LO +: BP];

         logic bank_wr;
         assign bank_wr = bus_wr && dec_hit && (dec_bank == 3'(b));

         gpio_bank #(
            .PINS (BP),
            .INV  (BINV)
         ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_in  (pin_in[LO +: BP]),
            .wr      (bank_wr),
            .rtype   (dec_type),
            .wd      (bus_wdata[BP-1:0]),
            .rdata   (bank_rdata[b]),
            .pin_out (pin_out[LO +: BP]),
            .pin_oe  (pin_oe[LO +: BP]),
            .stat_q  (stat_all[LO +: BP]),
            .mask_q  (mask_all[LO +: BP]),
            .irq     (bank_irq[b])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (dec_hit && dec_bank == 3'(b)) bus_rdata = bank_rdata[b];
      end
   end

   assign irq = |bank_irq;

endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
module gpio_banked_ctrl_chk #(
   parameter int NUM_PINS = 176,
   parameter int ADDR_W   = 12,
   parameter int LANE0    = 32
)(
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [31:0]         bus_wdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                irq,
   input logic [LANE0-1:0]    stat_lane0
);

   // R1: outputs and interrupt are quiet on the first cycle out of reset
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0 && !irq));

   // R3: a set write to bank 0 leaves every written-one lane high
   a_r3_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(12'h018)) |=>
      ((pin_out[LANE0-1:0] & $past(bus_wdata[LANE0-1:0])) == $past(bus_wdata[LANE0-1:0])));

   // R4: a clear write to bank 0 leaves every written-one lane low
   a_r4_clear_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(12'h024)) |=>
      ((pin_out[LANE0-1:0] & $past(bus_wdata[LANE0-1:0])) == '0));

   // R9: without a write to the bank 0 status word no status bit drops
   a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == ADDR_W'(12'h048)) |=>
      ((stat_lane0 & $past(stat_lane0)) == $past(stat_lane0)));

endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(
   .NUM_PINS (NUM_PINS),
   .ADDR_W   (ADDR_W),
   .LANE0    (LANE0)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .pin_out    (pin_out),
   .pin_oe     (pin_oe),
   .irq        (irq),
   .stat_lane0 (stat_all[LANE0-1:0])
);

// File: tb/test_gpio_banked_ctrl.sv
`timescale 1ns/1ps
module test_gpio_banked_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 176;
   localparam logic [191:0] INV  = 192'hF << 86;
   localparam logic [191:0] IMPL = (192'd1 << NP) - 192'd1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_v = '0;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;
   logic          irq;

   int checks = 0;
   int failures = 0;
   string cur_req = "R1";
   bit ready = 1'b0;

   // reference model state, one flat vector per register kind
   logic [191:0] m_out = '0, m_dir = INV & IMPL, m_rise = '0, m_fall = '0;
   logic [191:0] m_stat = '0, m_mask = '0, m_s1 = '0, m_s2 = '0, m_s3 = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_banked_ctrl i_gpio_banked_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_v),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq       (irq)
   );

   // address map from R2: kind codes 0 level .. 7 mask
   function automatic bit mdec(input logic [11:0] a, output int bk, output int ty);
      bk = 0; ty = 0;
      for (int b = 0; b < 6; b++) begin
         for (int t = 0; t < 8; t++) begin
            int off;
            int where;
            off   = (t == 7) ? 156 : t * 12;
            where = ((b < 3) ? b * 4 : 256 + (b - 3) * 4) + off;
            if (int'(a) == where) begin
               bk = b; ty = t;
               return 1'b1;
            end
         end
      end
      return 1'b0;
   endfunction

   function automatic logic [31:0] mread(input logic [11:0] a);
      int bk, ty;
      logic [191:0] v;
      if (!mdec(a, bk, ty)) return 32'h0;
      case (ty)
         0: v = m_s2;
         1: v = m_dir;
         4: v = m_rise;
         5: v = m_fall;
         6: v = m_stat;
         7: v = m_mask;
         default: v = '0;
      endcase
      return 32'(v >> (32 * bk));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_out = '0; m_dir = INV & IMPL; m_rise = '0; m_fall = '0;
         m_stat = '0; m_mask = '0; m_s1 = '0; m_s2 = '0; m_s3 = '0;
      end else begin
         logic [191:0] ev, wd, ln, clr;
         int bk, ty;
         bit h;
         ev  = (m_s2 & ~m_s3 & m_rise) | (~m_s2 & m_s3 & m_fall);
         h   = mdec(bus_addr, bk, ty);
         wd  = ({160'd0, bus_wdata} << (32 * bk)) & IMPL;
         ln  = ({160'd0, 32'hFFFF_FFFF} << (32 * bk)) & IMPL;
         clr = '0;
         if (bus_wr && h) begin
            case (ty)
               1: m_dir  = (m_dir  & ~ln) | wd;
               2: m_out  = m_out | wd;
               3: m_out  = m_out & ~wd;
               4: m_rise = (m_rise & ~ln) | wd;
               5: m_fall = (m_fall & ~ln) | wd;
               6: clr    = wd;
               7: m_mask = (m_mask & ~ln) | wd;
               default: ;
            endcase
         end
         m_stat = ((m_stat & ~clr) | ev) & IMPL;
         m_s3 = m_s2;
         m_s2 = m_s1;
         m_s1 = {16'd0, pin_v};
      end
      ready = 1'b1;
   end

   task automatic chk(input string req, input string what,
                      input logic [191:0] act, input logic [191:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // reference comparison on every clock, away from the active edge
   always @(negedge clk) begin
      if (ready) begin
         chk(cur_req, "pin_out", {16'd0, pin_out}, m_out & IMPL);
         chk(cur_req, "pin_oe", {16'd0, pin_oe}, (m_dir ^ INV) & IMPL);
         chk(cur_req, "irq", {191'd0, irq}, {191'd0, |(m_stat & m_mask)});
         chk(cur_req, "bus_rdata", {160'd0, bus_rdata}, {160'd0, mread(bus_addr)});
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
      @(negedge clk); #1;
      bus_addr = a;
      @(negedge clk);
      chk(req, $sformatf("read %h", a), {160'd0, bus_rdata}, {160'd0, exp});
   endtask

   task automatic setpin(input int idx, input logic v);
      @(negedge clk); #1;
      pin_v[idx] = v;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog all requirements: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R1 reset state
      cur_req = "R1";
      idle(3);
      #1 rst_n = 1'b1;
      rd(12'h014, 32'h03C0_0000, "R1");
      rd(12'h048, 32'h0, "R1");
      rd(12'h09C, 32'h0, "R1");
      rd(12'h030, 32'h0, "R1");
      chk("R1", "pin_oe", {16'd0, pin_oe}, '0);
      chk("R1", "irq", {191'd0, irq}, '0);

      // R2 map, both windows, holes and upper address bits
      cur_req = "R2";
      wr(12'h134, 32'hA5A5_0001);
      rd(12'h134, 32'hA5A5_0001, "R2");
      wr(12'h19C, 32'h1234_5678);
      rd(12'h19C, 32'h1234_5678, "R2");
      wr(12'h060, 32'hFFFF_FFFF);
      rd(12'h060, 32'h0, "R2");
      wr(12'h230, 32'hFFFF_FFFF);
      rd(12'h230, 32'h0, "R2");
      rd(12'h030, 32'h0, "R2");
      wr(12'h032, 32'hFFFF_FFFF);
      rd(12'h030, 32'h0, "R2");

      // R3 / R4 atomic set and clear
      cur_req = "R3";
      wr(12'h01C, 32'h0000_00F0);
      chk("R3", "pin_out[47:32]", {176'd0, pin_out[47:32]}, 192'h00F0);
      rd(12'h01C, 32'h0, "R3");
      cur_req = "R4";
      wr(12'h028, 32'h0000_0030);
      chk("R4", "pin_out[47:32]", {176'd0, pin_out[47:32]}, 192'h00C0);
      rd(12'h028, 32'h0, "R4");

      // R5 direction polarity
      cur_req = "R5";
      wr(12'h00C, 32'h0000_000F);
      chk("R5", "pin_oe[7:0]", {184'd0, pin_oe[7:0]}, 192'h0F);
      wr(12'h014, 32'h0);
      chk("R5", "pin_oe[95:80]", {176'd0, pin_oe[95:80]}, 192'h03C0);

      // R6 synchronised level, read-only
      cur_req = "R6";
      @(negedge clk); #1 pin_v[7:4] = 4'b1010;
      idle(2);
      rd(12'h000, 32'h0000_00A0, "R6");
      wr(12'h000, 32'hFFFF_FFFF);
      rd(12'h000, 32'h0000_00A0, "R6");

      // R7 / R8 edge capture
      cur_req = "R7";
      @(negedge clk); #1 pin_v = '0;
      idle(4);
      wr(12'h048, 32'hFFFF_FFFF);
      wr(12'h030, 32'h0000_0005);
      wr(12'h03C, 32'h0000_0006);
      @(negedge clk); #1 pin_v[2:0] = 3'b111;
      idle(3);
      rd(12'h048, 32'h0000_0005, "R7");
      cur_req = "R8";
      @(negedge clk); #1 pin_v[2:0] = 3'b000;
      idle(3);
      rd(12'h048, 32'h0000_0007, "R8");

      // R9 write-one-to-clear
      cur_req = "R9";
      wr(12'h048, 32'h0000_0001);
      rd(12'h048, 32'h0000_0006, "R9");
      wr(12'h048, 32'h0);
      rd(12'h048, 32'h0000_0006, "R9");
      wr(12'h048, 32'hFFFF_FFFF);
      rd(12'h048, 32'h0, "R9");

      // R10 edge and clear on the same edge: edge wins
      cur_req = "R10";
      setpin(0, 1'b1);
      idle(1);
      wr(12'h048, 32'h0000_0001);
      rd(12'h048, 32'h0000_0001, "R10");
      wr(12'h048, 32'h0000_0001);
      rd(12'h048, 32'h0, "R10");

      // R11 mask gating and OR over banks
      cur_req = "R11";
      setpin(0, 1'b0);
      idle(3);
      setpin(0, 1'b1);
      idle(3);
      chk("R11", "irq masked", {191'd0, irq}, '0);
      wr(12'h09C, 32'h0000_0001);
      chk("R11", "irq unmasked", {191'd0, irq}, 192'd1);
      wr(12'h09C, 32'h0);
      chk("R11", "irq remasked", {191'd0, irq}, '0);
      wr(12'h138, 32'h0000_0001);
      setpin(160, 1'b1);
      idle(3);
      chk("R11", "irq bank5 masked", {191'd0, irq}, '0);
      wr(12'h1A4, 32'hFFFF_FFFF);
      chk("R11", "irq bank5 unmasked", {191'd0, irq}, 192'd1);

      // R12 partial last bank
      cur_req = "R12";
      rd(12'h1A4, 32'h0000_FFFF, "R12");
      wr(12'h114, 32'hFFFF_FFFF);
      rd(12'h114, 32'h0000_FFFF, "R12");
      wr(12'h120, 32'hFFFF_FFFF);
      chk("R12", "pin_out[175:160]", {176'd0, pin_out[175:160]}, 192'hFFFF);
      rd(12'h120, 32'h0, "R12");
      idle(2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule